// File: doc/BRIEF.md
# Performance Monitor Counter Unit

A per-core event counting unit. It holds one dedicated cycle counter and a parameterised number (1 to 31) of 32-bit event counters. Each event counter picks one line out of a 1024-wide vector of single-cycle event pulses by a 10-bit event number. It can also be told to ignore pulses raised at particular privilege levels. Software programs and reads the unit through a flat word-addressed register port. Every counter that wraps past its all-ones value raises a sticky overflow flag. The enabled flags are ORed into one interrupt line.

A write takes effect at the clock edge on which `reg_we` is high. Read data is a combinational view of the addressed register, so a read always shows the state left by the previous edge. The enable and interrupt-enable masks are changed through separate set and clear offsets, so software never needs a read-modify-write. Event counters are reached indirectly through a select register. The cycle counter has its own direct offset.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset, every counter, event type, enable mask, interrupt-enable mask, overflow flag, the select value and the control bits are zero. `ovf_irq` is low. Offset 0 then reads only the counter-count field.
- R2: The control register is at offset 0. Bit 0 lets all counters run and bit 3 selects the divided cycle count. Only bits 5:0 are writable. Bits 1 and 2 are one-shot commands that always read as 0. Bits 15:11 read the parameter NUM_CNT.
- R3: The counter-enable mask is set through offset 1 and cleared through offset 2. The interrupt-enable mask is set through offset 3 and cleared through offset 4. Bit n belongs to event counter n and bit 31 to the cycle counter. A 1 in the write data acts on that bit and a 0 leaves it alone. Both offsets of a pair read the current mask. Bits of unimplemented counters stay 0.
- R4: An event counter adds exactly 1 on an edge where all of the following hold: control bit 0 is set, its enable bit is set, the event input indexed by its type bits 9:0 is high, and its level filter allows `priv_lvl`. Otherwise it holds.
- R5: In the level filter, type bit 30 blocks level 0 and bit 31 blocks level 1. Level 2 is counted only when bit 27 is set. Level 3 is never counted.
- R6: The event-type register of the selected counter is at offset 7. It keeps only the bits in mask 0xC80003FF, and its bits 9:0 are the event number.
- R7: A counter stepping from 0xFFFFFFFF to 0 sets its flag in the overflow register at offset 5. Writing 1 to a flag clears it. A flag set and a clear on the same edge leave the flag set.
- R8: `ovf_irq` is high exactly when some overflow flag is set together with its interrupt-enable bit.
- R9: The cycle counter, at offset 9, advances on every edge where control bit 0 and enable bit 31 are set. When control bit 3 is set, it advances only on every 64th such edge.
- R10: Writing control bit 1 zeroes all event counters. Writing control bit 2 zeroes the cycle counter and its divider phase. Both commands win over an increment or a count write on the same edge.
- R11: The select register is at offset 6 and 5 bits wide. Offsets 7 and 8 act on the selected counter. A select value of NUM_CNT or more makes offsets 7 and 8 read 0 and ignore writes. Offsets 10 to 15 read 0.
- R12: A write to offset 8 (selected event counter) or offset 9 (cycle counter) loads the written value. It overrides an increment on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data of the addressed register |
| evt_in | input | 1024 | Event pulses, one line per event number |
| priv_lvl | input | 2 | Current privilege level |
| ovf_irq | output | 1 | Combined overflow interrupt |

## Verification
Two functions can land on one edge. The first pair is a counter wrap together with a software write-one-to-clear of the same overflow flag. The second pair is an increment together with a zeroing command or a direct count write. A directed step drives a pulse into a counter preloaded with 0xFFFFFFFF while the same flag is being cleared, and expects the flag and the interrupt to survive. Further steps pair a pulse with control bit 1 and with a count write, and expect zero and the written value. A bench model, advanced on every edge, judges the random mix in which these coincidences recur on their own.

// File: rtl/pmu_pkg.sv
`timescale 1ns/10ps
package pmu_pkg;
  localparam int WORD_W  = 32;
  localparam int CYC_BIT = 31;
  localparam int SEL_W   = 5;
  localparam logic [WORD_W-1:0] TYPE_KEEP = 32'hC800_03FF;

  typedef enum logic [3:0] {
    RA_CTRL   = 4'd0,
    RA_EN_SET = 4'd1,
    RA_EN_CLR = 4'd2,
    RA_IE_SET = 4'd3,
    RA_IE_CLR = 4'd4,
    RA_OVF    = 4'd5,
    RA_SEL    = 4'd6,
    RA_TYPE   = 4'd7,
    RA_CNT    = 4'd8,
    RA_CYC    = 4'd9
  } reg_addr_e;

  // control bit positions
  localparam int C_RUN      = 0;
  localparam int C_ZERO_EV  = 1;
  localparam int C_ZERO_CYC = 2;
  localparam int C_DIV      = 3;
  localparam int C_NUM_LSB  = 11;
  localparam logic [5:0] CTRL_STORE = 6'b111001;

  // level filter bits in the event type
  localparam int T_NO_L1 = 31;
  localparam int T_NO_L0 = 30;
  localparam int T_L2    = 27;

  function automatic logic level_ok(input logic [WORD_W-1:0] t, input logic [1:0] lvl);
    case (lvl)
      2'd0:    level_ok = !t[T_NO_L0];
      2'd1:    level_ok = !t[T_NO_L1];
      2'd2:    level_ok = t[T_L2];
      default: level_ok = 1'b0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] impl_mask(input int n);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < CYC_BIT; i++) m[i] = (i < n);
    m[CYC_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pmu_evt_ctr.sv
`timescale 1ns/10ps
module pmu_evt_ctr
  import pmu_pkg::*;
#(
  parameter int EVT_BITS = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     armed,
  input  logic [(1<<EVT_BITS)-1:0] evt_in,
  input  logic [1:0]               lvl,
  input  logic                     zero_req,
  input  logic                     load_cnt,
  input  logic                     load_type,
  input  logic [WORD_W-1:0]        wdata,
  output logic [WORD_W-1:0]        cnt_o,
  output logic [WORD_W-1:0]        type_o,
  output logic                     wrap_o
);
  logic [WORD_W-1:0]   cnt_q, type_q;
  logic [EVT_BITS-1:0] evt_sel;
  logic                hit;

  assign evt_sel = type_q[EVT_BITS-1:0];
  assign hit     = armed && evt_in[evt_sel] && level_ok(type_q, lvl);
  assign wrap_o  = hit && !zero_req && !load_cnt && (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      type_q <= '0;
    end else begin
      if (zero_req)      cnt_q <= '0;
      else if (load_cnt) cnt_q <= wdata;
      else if (hit)      cnt_q <= cnt_q + 1'b1;
      if (load_type)     type_q <= wdata & TYPE_KEEP;
    end
  end

  assign cnt_o  = cnt_q;
  assign type_o = type_q;

  p_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    zero_req |=> cnt_q == '0);
  p_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (load_cnt && !zero_req) |=> cnt_q == $past(wdata));
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero_req && !load_cnt && !hit) |=> $stable(cnt_q));
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !zero_req && !load_cnt) |=> cnt_q == $past(cnt_q) + 32'd1);
  p_wrap_to_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> cnt_q == '0);
endmodule

// File: rtl/pmu_cyc_ctr.sv
`timescale 1ns/10ps
module pmu_cyc_ctr
  import pmu_pkg::*;
#(
  parameter int DIV_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              div_on,
  input  logic              zero_req,
  input  logic              load_cnt,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] cnt_o,
  output logic              wrap_o
);
  logic [DIV_LOG2-1:0] phase_q;
  logic [WORD_W-1:0]   cnt_q;
  logic                tick;

  assign tick   = run && (!div_on || (&phase_q));
  assign wrap_o = tick && !zero_req && !load_cnt && (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      cnt_q   <= '0;
    end else if (zero_req) begin
      phase_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (run) phase_q <= phase_q + 1'b1;
      if (load_cnt)  cnt_q <= wdata;
      else if (tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  p_cyc_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    zero_req |=> cnt_q == '0);
  p_cyc_div_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (div_on && !(&phase_q) && !zero_req && !load_cnt) |=> $stable(cnt_q));
  p_cyc_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !div_on && !zero_req && !load_cnt) |=> cnt_q == $past(cnt_q) + 32'd1);
endmodule

// File: rtl/perf_mon_unit.sv
`timescale 1ns/10ps
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int NUM_CNT  = 6,
  parameter int EVT_BITS = 10,
  parameter int DIV_LOG2 = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [3:0]               reg_addr,
  input  logic [WORD_W-1:0]        reg_wdata,
  output logic [WORD_W-1:0]        reg_rdata,
  input  logic [(1<<EVT_BITS)-1:0] evt_in,
  input  logic [1:0]               priv_lvl,
  output logic                     ovf_irq
);
  localparam logic [WORD_W-1:0] IMPL = impl_mask(NUM_CNT);

  logic [5:0]        ctrl_q;
  logic [WORD_W-1:0] en_q, ie_q, ovf_q;
  logic [SEL_W-1:0]  sel_q;
  logic              sel_ok, run_all, zero_ev, zero_cyc;
  logic [WORD_W-1:0] en_set, en_clr, ie_set, ie_clr, ovf_clr, wrap_vec;
  logic [WORD_W-1:0] ev_cnt  [NUM_CNT];
  logic [WORD_W-1:0] ev_type [NUM_CNT];
  logic [NUM_CNT-1:0] ev_wrap;
  logic [WORD_W-1:0] cyc_cnt;
  logic              cyc_wrap;

  function automatic logic wr_at(input logic we, input logic [3:0] a, input reg_addr_e ra);
    return we && (a == ra);
  endfunction

  assign run_all  = ctrl_q[C_RUN];
  assign zero_ev  = wr_at(reg_we, reg_addr, RA_CTRL) && reg_wdata[C_ZERO_EV];
  assign zero_cyc = wr_at(reg_we, reg_addr, RA_CTRL) && reg_wdata[C_ZERO_CYC];
  assign sel_ok   = int'(sel_q) < NUM_CNT;

  assign en_set  = wr_at(reg_we, reg_addr, RA_EN_SET) ? reg_wdata : '0;
  assign en_clr  = wr_at(reg_we, reg_addr, RA_EN_CLR) ? reg_wdata : '0;
  assign ie_set  = wr_at(reg_we, reg_addr, RA_IE_SET) ? reg_wdata : '0;
  assign ie_clr  = wr_at(reg_we, reg_addr, RA_IE_CLR) ? reg_wdata : '0;
  assign ovf_clr = wr_at(reg_we, reg_addr, RA_OVF)    ? reg_wdata : '0;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_ctr
    logic ld_cnt, ld_type;
    assign ld_cnt  = wr_at(reg_we, reg_addr, RA_CNT)  && (sel_q == SEL_W'(g));
    assign ld_type = wr_at(reg_we, reg_addr, RA_TYPE) && (sel_q == SEL_W'(g));

    pmu_evt_ctr #(.EVT_BITS(EVT_BITS)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .armed    (run_all && en_q[g]),
      .evt_in   (evt_in),
      .lvl      (priv_lvl),
      .zero_req (zero_ev),
      .load_cnt (ld_cnt),
      .load_type(ld_type),
      .wdata    (reg_wdata),
      .cnt_o    (ev_cnt[g]),
      .type_o   (ev_type[g]),
      .wrap_o   (ev_wrap[g])
    );

    p_flag_on_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ev_wrap[g] |=> ovf_q[g]);
    p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_clr[g] && !ev_wrap[g]) |=> !ovf_q[g]);
  end

  pmu_cyc_ctr #(.DIV_LOG2(DIV_LOG2)) u_cyc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_all && en_q[CYC_BIT]),
    .div_on  (ctrl_q[C_DIV]),
    .zero_req(zero_cyc),
    .load_cnt(wr_at(reg_we, reg_addr, RA_CYC)),
    .wdata   (reg_wdata),
    .cnt_o   (cyc_cnt),
    .wrap_o  (cyc_wrap)
  );

  always_comb begin
    wrap_vec = '0;
    for (int i = 0; i < NUM_CNT; i++) wrap_vec[i] = ev_wrap[i];
    wrap_vec[CYC_BIT] = cyc_wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      en_q   <= '0;
      ie_q   <= '0;
      ovf_q  <= '0;
      sel_q  <= '0;
    end else begin
      if (wr_at(reg_we, reg_addr, RA_CTRL)) ctrl_q <= reg_wdata[5:0] & CTRL_STORE;
      if (wr_at(reg_we, reg_addr, RA_SEL))  sel_q  <= reg_wdata[SEL_W-1:0];
      en_q  <= (en_q | en_set) & ~en_clr & IMPL;
      ie_q  <= (ie_q | ie_set) & ~ie_clr & IMPL;
      ovf_q <= ((ovf_q & ~ovf_clr) | wrap_vec) & IMPL;
    end
  end

  assign ovf_irq = |(ovf_q & ie_q);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: begin
        reg_rdata[5:0] = ctrl_q;
        reg_rdata[C_NUM_LSB +: 5] = 5'(NUM_CNT);
      end
      RA_EN_SET, RA_EN_CLR: reg_rdata = en_q;
      RA_IE_SET, RA_IE_CLR: reg_rdata = ie_q;
      RA_OVF:  reg_rdata = ovf_q;
      RA_SEL:  reg_rdata[SEL_W-1:0] = sel_q;
      RA_TYPE: for (int i = 0; i < NUM_CNT; i++)
                 if (sel_ok && sel_q == SEL_W'(i)) reg_rdata = ev_type[i];
      RA_CNT:  for (int i = 0; i < NUM_CNT; i++)
                 if (sel_ok && sel_q == SEL_W'(i)) reg_rdata = ev_cnt[i];
      RA_CYC:  reg_rdata = cyc_cnt;
      default: reg_rdata = '0;
    endcase
  end

  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> (ovf_q != '0 && ie_q != '0));
  p_cyc_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_wrap |=> ovf_q[CYC_BIT]);
endmodule

// File: tb/sim_perf_mon_unit.sv
`timescale 1ns/10ps
module sim_perf_mon_unit;
  localparam int NC = 6;
  localparam bit [31:0] IMPL = 32'h8000_003F;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [1023:0] evt_in = '0;
  logic [1:0]    priv_lvl = '0;
  logic          ovf_irq;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  perf_mon_unit #(.NUM_CNT(NC), .EVT_BITS(10), .DIV_LOG2(6)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
    .priv_lvl(priv_lvl), .ovf_irq(ovf_irq)
  );

  // bench model state
  bit [5:0]  m_ctrl;
  bit [31:0] m_en, m_ie, m_ovf, m_cyc;
  bit [4:0]  m_sel;
  bit [5:0]  m_pre;
  bit [31:0] m_type [NC];
  bit [31:0] m_cnt  [NC];

  function automatic bit allowed(bit [31:0] t, bit [1:0] lv);
    bit [3:0] ok;
    ok = {1'b0, t[27], ~t[31], ~t[30]};
    return ok[lv];
  endfunction

  function automatic bit [31:0] m_read(bit [3:0] a);
    case (a)
      4'd0: return {16'h0, 5'(NC), 5'b0, m_ctrl};
      4'd1, 4'd2: return m_en;
      4'd3, 4'd4: return m_ie;
      4'd5: return m_ovf;
      4'd6: return {27'b0, m_sel};
      4'd7: return (m_sel < NC) ? m_type[m_sel] : 32'h0;
      4'd8: return (m_sel < NC) ? m_cnt[m_sel] : 32'h0;
      4'd9: return m_cyc;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(bit [3:0] a);
    case (a)
      4'd0: return "R2";
      4'd1, 4'd2, 4'd3, 4'd4: return "R3";
      4'd5: return "R7";
      4'd7: return "R6";
      4'd8: return "R4";
      4'd9: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic m_step(bit we, bit [3:0] a, bit [31:0] d, bit [1023:0] ev, bit [1:0] lv);
    bit [31:0] n_cnt [NC];
    bit [31:0] wraps, n_cyc;
    bit [5:0]  n_pre;
    bit run, z_ev, z_cy, cy_go, tick;
    run  = m_ctrl[0];
    z_ev = we && a == 4'd0 && d[1];
    z_cy = we && a == 4'd0 && d[2];
    wraps = '0;
    for (int i = 0; i < NC; i++) begin
      bit hit;
      hit = run && m_en[i] && ev[m_type[i][9:0]] && allowed(m_type[i], lv);
      if (z_ev) n_cnt[i] = 0;
      else if (we && a == 4'd8 && m_sel == 5'(i)) n_cnt[i] = d;
      else if (hit) begin
        n_cnt[i] = m_cnt[i] + 1;
        if (m_cnt[i] == 32'hFFFF_FFFF) wraps[i] = 1'b1;
      end else n_cnt[i] = m_cnt[i];
    end
    cy_go = run && m_en[31];
    tick  = cy_go && (!m_ctrl[3] || m_pre == 6'd63);
    if (z_cy) begin
      n_cyc = 0; n_pre = 0;
    end else begin
      n_pre = cy_go ? m_pre + 6'd1 : m_pre;
      if (we && a == 4'd9) n_cyc = d;
      else if (tick) begin
        n_cyc = m_cyc + 1;
        if (m_cyc == 32'hFFFF_FFFF) wraps[31] = 1'b1;
      end else n_cyc = m_cyc;
    end
    m_ovf = ((m_ovf & ~((we && a == 4'd5) ? d : 32'h0)) | wraps) & IMPL;
    if (we && a == 4'd1) m_en = m_en | (d & IMPL);
    if (we && a == 4'd2) m_en = m_en & ~d;
    if (we && a == 4'd3) m_ie = m_ie | (d & IMPL);
    if (we && a == 4'd4) m_ie = m_ie & ~d;
    if (we && a == 4'd7 && m_sel < NC) m_type[m_sel] = d & 32'hC800_03FF;
    if (we && a == 4'd0) m_ctrl = d[5:0] & 6'b111001;
    if (we && a == 4'd6) m_sel = d[4:0];
    for (int i = 0; i < NC; i++) m_cnt[i] = n_cnt[i];
    m_cyc = n_cyc;
    m_pre = n_pre;
  endtask

  task automatic chk(logic [31:0] act, bit [31:0] exp, string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: check the addressed read and the interrupt, then drive and advance
  task automatic step(bit we, bit [3:0] a, bit [31:0] d, bit [1023:0] ev, bit [1:0] lv, bit [3:0] ra);
    reg_we = 1'b0; reg_addr = ra; #0.1;
    chk(reg_rdata, m_read(ra), tag_of(ra));
    chk({31'b0, ovf_irq}, {31'b0, |(m_ovf & m_ie)}, "R8");
    reg_we = we; reg_addr = a; reg_wdata = d; evt_in = ev; priv_lvl = lv;
    m_step(we, a, d, ev, lv);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(bit [3:0] a, bit [31:0] d);
    step(1'b1, a, d, '0, 2'd0, 4'd0);
  endtask

  task automatic pulse(bit [1:0] lv);
    bit [1023:0] ev;
    ev = '0; ev[3] = 1'b1;
    step(1'b0, 4'd0, 32'h0, ev, lv, 4'd8);
  endtask

  task automatic peek(bit [3:0] a, bit [31:0] exp, string tag);
    reg_we = 1'b0; reg_addr = a; #0.1;
    chk(reg_rdata, exp, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    bit [1023:0] ev;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    peek(4'd0, 32'h0000_3000, "R1");
    for (int a = 1; a < 16; a++) peek(4'(a), 32'h0, "R1");
    chk({31'b0, ovf_irq}, 32'h0, "R1");

    // R2: writable bits, one-shot bits, count field
    wr(4'd0, 32'hFFFF_FFFF);
    peek(4'd0, 32'h0000_3039, "R2");

    // R3: set / clear pairs and unimplemented bits
    wr(4'd1, 32'hFFFF_FFFF);
    peek(4'd1, 32'h8000_003F, "R3");
    wr(4'd2, 32'h0000_0005);
    peek(4'd2, 32'h8000_003A, "R3");
    wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd3, 32'h0000_0040);
    peek(4'd4, 32'h0, "R3");

    // R9: divided cycle count, then undivided
    wr(4'd1, 32'h8000_0000);
    wr(4'd0, 32'h0000_000D);
    repeat (127) step(1'b0, 4'd0, 32'h0, '0, 2'd0, 4'd9);
    peek(4'd9, 32'd1, "R9");
    step(1'b0, 4'd0, 32'h0, '0, 2'd0, 4'd9);
    peek(4'd9, 32'd2, "R9");
    wr(4'd0, 32'h0000_0005);
    peek(4'd9, 32'd0, "R10");
    repeat (10) step(1'b0, 4'd0, 32'h0, '0, 2'd0, 4'd9);
    peek(4'd9, 32'd10, "R9");
    wr(4'd2, 32'h8000_0000);

    // R7 / R8: wrap and clear on the same edge
    wr(4'd0, 32'h0000_0003);
    wr(4'd6, 32'd0);
    wr(4'd7, 32'h0000_0003);
    wr(4'd8, 32'hFFFF_FFFF);
    wr(4'd1, 32'h0000_0001);
    wr(4'd3, 32'h0000_0001);
    ev = '0; ev[3] = 1'b1;
    step(1'b1, 4'd5, 32'h0000_0001, ev, 2'd0, 4'd5);
    peek(4'd5, 32'h0000_0001, "R7");
    peek(4'd8, 32'h0, "R7");
    chk({31'b0, ovf_irq}, 32'd1, "R8");
    wr(4'd5, 32'h0000_0001);
    peek(4'd5, 32'h0, "R7");
    chk({31'b0, ovf_irq}, 32'd0, "R8");

    // R5: level filter
    wr(4'd7, 32'h8000_0003);
    pulse(2'd1); peek(4'd8, 32'd0, "R5");
    pulse(2'd0); peek(4'd8, 32'd1, "R5");
    pulse(2'd2); peek(4'd8, 32'd1, "R5");
    wr(4'd7, 32'h0800_0003);
    pulse(2'd2); peek(4'd8, 32'd2, "R5");
    pulse(2'd3); peek(4'd8, 32'd2, "R5");
    pulse(2'd1); peek(4'd8, 32'd3, "R4");

    // R6: type mask
    wr(4'd7, 32'hFFFF_FFFF);
    peek(4'd7, 32'hC800_03FF, "R6");
    wr(4'd7, 32'h0000_0003);

    // R12: count write beats increment
    step(1'b1, 4'd8, 32'd5, ev, 2'd0, 4'd8);
    peek(4'd8, 32'd5, "R12");
    // R10: zero command beats increment
    step(1'b1, 4'd0, 32'h0000_0003, ev, 2'd0, 4'd8);
    peek(4'd8, 32'd0, "R10");

    // R11: out-of-range select
    wr(4'd8, 32'd7);
    wr(4'd6, 32'd6);
    wr(4'd8, 32'h0000_1234);
    wr(4'd7, 32'hFFFF_FFFF);
    peek(4'd8, 32'h0, "R11");
    peek(4'd7, 32'h0, "R11");
    wr(4'd6, 32'd0);
    peek(4'd8, 32'd7, "R11");
    peek(4'd7, 32'h3, "R11");

    // random mix judged by the model
    for (int n = 0; n < 6000; n++) begin
      bit we;
      bit [3:0] a;
      bit [31:0] d;
      bit [1:0] lv;
      we = $urandom_range(0, 99) >= 40;
      a  = 4'($urandom_range(0, 10));
      d  = $urandom;
      case (a)
        4'd0: begin
          d = d & 32'hFFFF_FFF0;
          d[0] = $urandom_range(0, 9) < 8;
          d[3] = $urandom_range(0, 9) < 2;
          d[1] = $urandom_range(0, 19) == 0;
          d[2] = $urandom_range(0, 19) == 0;
        end
        4'd6: if ($urandom_range(0, 3) != 0) d = $urandom_range(0, 7);
        4'd7: d = (d & 32'hFFFF_FC00) | $urandom_range(0, 7);
        4'd8, 4'd9: if ($urandom_range(0, 1) == 0) d = 32'hFFFF_FFF0 | 32'($urandom_range(0, 15));
        default: ;
      endcase
      ev = '0;
      ev[7:0] = 8'($urandom);
      if ($urandom_range(0, 9) == 0) ev[$urandom_range(8, 1023)] = 1'b1;
      lv = 2'($urandom_range(0, 3));
      step(we, a, d, ev, lv, 4'($urandom_range(0, 10)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule